// File: doc/BRIEF.md
# Register Undo History Buffer

This block keeps an undo log for the register file of a pipelined core that issues in order but lets instructions finish out of order. Each issued instruction takes the next slot at the tail of a circular queue. The slot is tagged with the instruction's destination register index and its address, and the caller gets the slot number back. When the instruction finishes, the execution side reports the slot number together with the value that the write is about to overwrite. The buffer keeps that old value in the slot. Slots leave from the head in program order, and only once they have finished. A younger finished entry therefore waits behind an older unfinished one, and up to `RET_MAX` finished entries leave together in one cycle.

An instruction can only raise its exception once its entry is at the head. When the head entry is finished and flagged as an exception, the buffer enters rollback. It visits the entries younger than the head one per cycle, starting at the youngest and moving toward the head. For each entry that had finished, it drives the saved old value back into the register file through a restore port. Entries that never finished are skipped. After the walk, the queue is emptied and a one-cycle done strobe presents the address of the excepting instruction. The excepting entry's own result is never committed, so nothing is restored for it. While the rollback runs, issue and completion requests are refused.

Top module: `reg_undo_buffer`

## Requirements
- R1: After reset, `alloc_ready` is 1, `alloc_slot` is 0, and `rf_restore_we` and `rb_done` are 0.
- R2: An accepted allocation (`alloc_valid` and `alloc_ready` both high at a clock edge) takes the slot shown on `alloc_slot`. Slots are handed out in increasing order modulo `DEPTH`.
- R3: After `DEPTH` accepted allocations with nothing retired, `alloc_ready` is 0.
- R4: Entries retire only from the head, in program order, and only once finished. A finished younger entry does not free space while an older one is unfinished. Once the head finishes, it and the finished entries directly behind it retire, up to `RET_MAX` per cycle.
- R5: A completion with `cmpl_exc` = 1 starts a rollback only when its entry is at the head. An excepting entry behind an unfinished older entry waits, and it produces neither restore writes nor a done strobe until it becomes the head.
- R6: A rollback visits the entries strictly younger than the excepting head, one per clock, youngest first. For each finished entry it pulses `rf_restore_we` with that entry's destination index and saved old value. Unfinished entries produce no write.
- R7: After the walk, `rb_done` is high for exactly one cycle, with `rb_pc` holding the excepting instruction's address. From that cycle on, the queue is empty: `alloc_ready` is 1 and `alloc_slot` is 0.
- R8: While a rollback is in progress, `alloc_ready` is 0. A completion report presented during the rollback is ignored and leads to no restore write.
- R9: `rf_restore_we` is 0 whenever no rollback is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Issue request for one instruction |
| alloc_ready | output | 1 | Buffer can take an allocation this cycle |
| alloc_dest | input | IDX_W | Destination register index of the issuing instruction |
| alloc_pc | input | ADDR_W | Address of the issuing instruction |
| alloc_slot | output | log2(DEPTH) | Slot the next accepted allocation receives |
| cmpl_valid | input | 1 | Completion report |
| cmpl_slot | input | log2(DEPTH) | Slot of the finishing instruction |
| cmpl_old | input | DATA_W | Register value overwritten by the finishing instruction |
| cmpl_exc | input | 1 | Finishing instruction raised an exception |
| rf_restore_we | output | 1 | Register-file restore write strobe |
| rf_restore_idx | output | IDX_W | Register index being restored |
| rf_restore_data | output | DATA_W | Value written back |
| rb_done | output | 1 | One-cycle strobe at the end of a rollback |
| rb_pc | output | ADDR_W | Address of the excepting instruction, valid with `rb_done` |

## Verification
The bound checker checks the following properties on every cycle:
- slot numbers advance by one per accepted allocation;
- `alloc_ready` stays low throughout a rollback;
- restore writes occur only inside a rollback;
- the done strobe lasts a single cycle and leaves an empty queue.

Some behaviours can only be shown by the bench's scenarios:
- the exact restore sequence, meaning its youngest-first order, the skipping of unfinished slots, and the index and value pairs;
- a completion offered mid-rollback being dropped;
- an excepting entry waiting behind an unfinished older one;
- in-order retirement freeing exactly the expected space, observed through the slot numbers and the full condition after a wrap of the pointers.

// File: rtl/regundo_pkg.sv
package regundo_pkg;
  typedef enum logic [0:0] {
    RU_RUN  = 1'b0,
    RU_ROLL = 1'b1
  } ru_mode_e;
endpackage

// File: rtl/regundo_slots.sv
module regundo_slots #(
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 5,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_alloc,
  input  logic [PTR_W-1:0]  alloc_ptr,
  input  logic [IDX_W-1:0]  alloc_dest,
  input  logic [ADDR_W-1:0] alloc_pc,
  input  logic              wr_cmpl,
  input  logic [PTR_W-1:0]  cmpl_ptr,
  input  logic [DATA_W-1:0] cmpl_old,
  input  logic [PTR_W-1:0]  walk_ptr,
  input  logic [PTR_W-1:0]  head_ptr,
  input  logic              finish,
  output logic [IDX_W-1:0]  rd_dest,
  output logic [DATA_W-1:0] rd_old,
  output logic [ADDR_W-1:0] rb_pc
);
  // Three single-write, single-read memories, one per field, so each maps to block RAM.
  logic [IDX_W-1:0]  dest_mem [DEPTH];
  logic [DATA_W-1:0] old_mem  [DEPTH];
  logic [ADDR_W-1:0] pc_mem   [DEPTH];
  logic [ADDR_W-1:0] head_pc;

  always_ff @(posedge clk) begin
    if (wr_alloc) dest_mem[alloc_ptr] <= alloc_dest;
    rd_dest <= dest_mem[walk_ptr];
  end

  always_ff @(posedge clk) begin
    if (wr_cmpl) old_mem[cmpl_ptr] <= cmpl_old;
    rd_old <= old_mem[walk_ptr];
  end

  always_ff @(posedge clk) begin
    if (wr_alloc) pc_mem[alloc_ptr] <= alloc_pc;
    head_pc <= pc_mem[head_ptr];
  end

  // The head is frozen during rollback, so head_pc holds the excepting address.
  always_ff @(posedge clk) begin
    if (rst)         rb_pc <= '0;
    else if (finish) rb_pc <= head_pc;
  end
endmodule

// File: rtl/regundo_ctrl.sv
module regundo_ctrl
  import regundo_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int RET_MAX = 2,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_valid,
  output logic             alloc_ready,
  output logic             alloc_fire,
  output logic [PTR_W-1:0] tail_ptr,
  input  logic             cmpl_valid,
  input  logic [PTR_W-1:0] cmpl_slot,
  input  logic             cmpl_exc,
  output logic             cmpl_take,
  output logic [PTR_W-1:0] head_ptr,
  output logic [PTR_W-1:0] walk_ptr,
  output logic             finish,
  output logic             rolling,
  output logic             restore_we,
  output logic             rb_done
);
  logic [DEPTH-1:0] vld_q, dn_q, ex_q;
  logic [PTR_W-1:0] head_q, tail_q, walk_q;
  logic [CNT_W-1:0] cnt_q, left_q, nret;
  ru_mode_e         mode_q;
  logic             trig, run_ok;

  assign trig        = (mode_q == RU_RUN) && vld_q[head_q] && dn_q[head_q] && ex_q[head_q];
  assign alloc_ready = (mode_q == RU_RUN) && !trig && (cnt_q != CNT_W'(DEPTH));
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign cmpl_take   = cmpl_valid && (mode_q == RU_RUN) && vld_q[cmpl_slot] && !dn_q[cmpl_slot];
  assign finish      = (mode_q == RU_ROLL) && (left_q == '0);
  assign rolling     = (mode_q == RU_ROLL);
  assign head_ptr    = head_q;
  assign tail_ptr    = tail_q;
  assign walk_ptr    = walk_q;

  // Count the contiguous run of clean finished entries starting at the head.
  always_comb begin
    nret   = '0;
    run_ok = (mode_q == RU_RUN);
    for (int k = 0; k < RET_MAX; k++) begin
      if (run_ok && vld_q[head_q + PTR_W'(k)] && dn_q[head_q + PTR_W'(k)]
          && !ex_q[head_q + PTR_W'(k)])
        nret = nret + CNT_W'(1);
      else
        run_ok = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q      <= '0;
      dn_q       <= '0;
      ex_q       <= '0;
      head_q     <= '0;
      tail_q     <= '0;
      walk_q     <= '0;
      cnt_q      <= '0;
      left_q     <= '0;
      mode_q     <= RU_RUN;
      restore_we <= 1'b0;
      rb_done    <= 1'b0;
    end else begin
      restore_we <= 1'b0;
      rb_done    <= 1'b0;
      if (mode_q == RU_RUN) begin
        if (trig) begin
          mode_q <= RU_ROLL;
          walk_q <= tail_q - PTR_W'(1);
          left_q <= cnt_q - CNT_W'(1);
        end else begin
          for (int k = 0; k < RET_MAX; k++) begin
            if (CNT_W'(k) < nret) begin
              vld_q[head_q + PTR_W'(k)] <= 1'b0;
              dn_q[head_q + PTR_W'(k)]  <= 1'b0;
              ex_q[head_q + PTR_W'(k)]  <= 1'b0;
            end
          end
          head_q <= head_q + PTR_W'(nret);
        end
        if (alloc_fire) begin
          vld_q[tail_q] <= 1'b1;
          dn_q[tail_q]  <= 1'b0;
          ex_q[tail_q]  <= 1'b0;
          tail_q        <= tail_q + PTR_W'(1);
        end
        if (cmpl_take) begin
          dn_q[cmpl_slot] <= 1'b1;
          ex_q[cmpl_slot] <= cmpl_exc;
        end
        cnt_q <= cnt_q + CNT_W'(alloc_fire) - nret;
      end else begin
        if (left_q != '0) begin
          restore_we <= dn_q[walk_q];
          walk_q     <= walk_q - PTR_W'(1);
          left_q     <= left_q - CNT_W'(1);
        end else begin
          mode_q  <= RU_RUN;
          vld_q   <= '0;
          dn_q    <= '0;
          ex_q    <= '0;
          head_q  <= '0;
          tail_q  <= '0;
          cnt_q   <= '0;
          rb_done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/reg_undo_buffer.sv
module reg_undo_buffer #(
  parameter int DEPTH   = 8,
  parameter int RET_MAX = 2,
  parameter int IDX_W   = 5,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32,
  localparam int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic [IDX_W-1:0]  alloc_dest,
  input  logic [ADDR_W-1:0] alloc_pc,
  output logic [PTR_W-1:0]  alloc_slot,
  input  logic              cmpl_valid,
  input  logic [PTR_W-1:0]  cmpl_slot,
  input  logic [DATA_W-1:0] cmpl_old,
  input  logic              cmpl_exc,
  output logic              rf_restore_we,
  output logic [IDX_W-1:0]  rf_restore_idx,
  output logic [DATA_W-1:0] rf_restore_data,
  output logic              rb_done,
  output logic [ADDR_W-1:0] rb_pc
);
  logic             alloc_fire, cmpl_take, finish, rolling;
  logic [PTR_W-1:0] head_ptr, walk_ptr, tail_ptr;

  assign alloc_slot = tail_ptr;

  regundo_ctrl #(.DEPTH(DEPTH), .RET_MAX(RET_MAX)) u_ctrl (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_fire(alloc_fire),
    .tail_ptr(tail_ptr),
    .cmpl_valid(cmpl_valid), .cmpl_slot(cmpl_slot), .cmpl_exc(cmpl_exc),
    .cmpl_take(cmpl_take),
    .head_ptr(head_ptr), .walk_ptr(walk_ptr), .finish(finish), .rolling(rolling),
    .restore_we(rf_restore_we), .rb_done(rb_done)
  );

  regundo_slots #(.DEPTH(DEPTH), .IDX_W(IDX_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_slots (
    .clk(clk), .rst(rst),
    .wr_alloc(alloc_fire), .alloc_ptr(tail_ptr), .alloc_dest(alloc_dest), .alloc_pc(alloc_pc),
    .wr_cmpl(cmpl_take), .cmpl_ptr(cmpl_slot), .cmpl_old(cmpl_old),
    .walk_ptr(walk_ptr), .head_ptr(head_ptr), .finish(finish),
    .rd_dest(rf_restore_idx), .rd_old(rf_restore_data), .rb_pc(rb_pc)
  );
endmodule

// File: rtl/regundo_chk.sv
module regundo_chk #(
  parameter int PTR_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic [PTR_W-1:0] alloc_slot,
  input logic             rf_restore_we,
  input logic             rolling,
  input logic             rb_done
);
  a_r2_slot_advance: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && alloc_ready) |=> (alloc_slot == PTR_W'($past(alloc_slot) + 1'b1)));

  a_r8_stall_in_rollback: assert property (@(posedge clk) disable iff (rst)
    rolling |-> !alloc_ready);

  a_r9_restore_only_rolling: assert property (@(posedge clk) disable iff (rst)
    rf_restore_we |-> rolling);

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    rb_done |=> !rb_done);

  a_r7_empty_after_done: assert property (@(posedge clk) disable iff (rst)
    rb_done |-> (alloc_ready && alloc_slot == '0 && !rolling));
endmodule

bind reg_undo_buffer regundo_chk #(.PTR_W($clog2(DEPTH))) u_chk (
  .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
  .alloc_slot(alloc_slot), .rf_restore_we(rf_restore_we), .rolling(rolling),
  .rb_done(rb_done)
);

// File: tb/sim_reg_undo_buffer.sv
module sim_reg_undo_buffer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        alloc_valid = 1'b0;
  logic        alloc_ready;
  logic [4:0]  alloc_dest = '0;
  logic [31:0] alloc_pc = '0;
  logic [2:0]  alloc_slot;
  logic        cmpl_valid = 1'b0;
  logic [2:0]  cmpl_slot = '0;
  logic [31:0] cmpl_old = '0;
  logic        cmpl_exc = 1'b0;
  logic        rf_restore_we;
  logic [4:0]  rf_restore_idx;
  logic [31:0] rf_restore_data;
  logic        rb_done;
  logic [31:0] rb_pc;

  int checks = 0;
  int errors = 0;
  int n_rest = 0;
  int n_done = 0;
  logic [4:0]  log_idx [16];
  logic [31:0] log_val [16];
  logic [31:0] last_pc = '0;

  always #5 clk = ~clk;

  reg_undo_buffer u0 (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_dest(alloc_dest), .alloc_pc(alloc_pc), .alloc_slot(alloc_slot),
    .cmpl_valid(cmpl_valid), .cmpl_slot(cmpl_slot), .cmpl_old(cmpl_old), .cmpl_exc(cmpl_exc),
    .rf_restore_we(rf_restore_we), .rf_restore_idx(rf_restore_idx),
    .rf_restore_data(rf_restore_data), .rb_done(rb_done), .rb_pc(rb_pc)
  );

  // Alloc vector table: {dest, pc, expected slot}
  localparam logic [39:0] ATAB [8] = '{
    {5'd1, 32'h1000, 3'd0}, {5'd2, 32'h1004, 3'd1}, {5'd3, 32'h1008, 3'd2},
    {5'd4, 32'h100C, 3'd3}, {5'd5, 32'h1010, 3'd4}, {5'd6, 32'h1014, 3'd5},
    {5'd7, 32'h1018, 3'd6}, {5'd8, 32'h101C, 3'd7}
  };

  always @(negedge clk) begin
    if (!rst) begin
      if (rf_restore_we) begin
        if (n_rest < 16) begin
          log_idx[n_rest] = rf_restore_idx;
          log_val[n_rest] = rf_restore_data;
        end
        n_rest++;
      end
      if (rb_done) begin
        n_done++;
        last_pc = rb_pc;
      end
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_alloc(input logic [4:0] d, input logic [31:0] pc, input logic [2:0] exp_slot);
    @(negedge clk);
    chk(alloc_ready == 1'b1, "R2 ready", {31'd0, alloc_ready}, 32'd1);
    chk(alloc_slot == exp_slot, "R2 slot", {29'd0, alloc_slot}, {29'd0, exp_slot});
    alloc_valid = 1'b1; alloc_dest = d; alloc_pc = pc;
    @(posedge clk);
    @(negedge clk);
    alloc_valid = 1'b0;
  endtask

  task automatic do_cmpl(input logic [2:0] s, input logic [31:0] old, input logic exc);
    @(negedge clk);
    cmpl_valid = 1'b1; cmpl_slot = s; cmpl_old = old; cmpl_exc = exc;
    @(posedge clk);
    @(negedge clk);
    cmpl_valid = 1'b0; cmpl_exc = 1'b0;
  endtask

  task automatic wait_done(input int prev);
    for (int i = 0; i < 40; i++) begin
      if (n_done != prev) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(alloc_ready == 1'b1, "R1 ready", {31'd0, alloc_ready}, 32'd1);
    chk(alloc_slot == 3'd0, "R1 slot", {29'd0, alloc_slot}, 32'd0);
    chk(!rf_restore_we && !rb_done, "R1 strobes", {30'd0, rf_restore_we, rb_done}, 32'd0);

    // R2 table-driven allocation of the whole buffer
    for (int i = 0; i < 8; i++)
      do_alloc(ATAB[i][39:35], ATAB[i][34:3], ATAB[i][2:0]);
    chk(alloc_ready == 1'b0, "R3 full", {31'd0, alloc_ready}, 32'd0);

    // R4 younger finished entries do not free space
    do_cmpl(3'd2, 32'hA002, 1'b0);
    do_cmpl(3'd5, 32'hA005, 1'b0);
    do_cmpl(3'd6, 32'hA006, 1'b0);
    repeat (3) @(negedge clk);
    chk(alloc_ready == 1'b0, "R4 head blocks", {31'd0, alloc_ready}, 32'd0);
    chk(n_rest == 0, "R9 no restore in run", n_rest, 32'd0);

    // R5/R6 head exception, then R8 completion during rollback is dropped
    do_cmpl(3'd0, 32'hEEEE, 1'b1);
    @(negedge clk);
    chk(alloc_ready == 1'b0, "R8 stall", {31'd0, alloc_ready}, 32'd0);
    cmpl_valid = 1'b1; cmpl_slot = 3'd7; cmpl_old = 32'hDEAD;
    @(negedge clk);
    cmpl_valid = 1'b0;
    wait_done(0);
    chk(n_done == 1, "R7 done", n_done, 32'd1);
    chk(n_rest == 3, "R6 R8 restore count", n_rest, 32'd3);
    chk(log_idx[0] == 5'd7 && log_val[0] == 32'hA006, "R6 first", log_val[0], 32'hA006);
    chk(log_idx[1] == 5'd6 && log_val[1] == 32'hA005, "R6 second", log_val[1], 32'hA005);
    chk(log_idx[2] == 5'd3 && log_val[2] == 32'hA002, "R6 third", log_val[2], 32'hA002);
    chk(last_pc == 32'h1000, "R7 pc", last_pc, 32'h1000);
    @(negedge clk);
    chk(alloc_ready == 1'b1 && alloc_slot == 3'd0, "R7 empty", {29'd0, alloc_slot}, 32'd0);
    chk(n_done == 1, "R7 single pulse", n_done, 32'd1);

    // R4 retirement in order then reuse of all space (with wrap)
    do_alloc(5'd10, 32'h2000, 3'd0);
    do_alloc(5'd11, 32'h2004, 3'd1);
    do_alloc(5'd12, 32'h2008, 3'd2);
    do_cmpl(3'd1, 32'h1, 1'b0);
    do_cmpl(3'd2, 32'h2, 1'b0);
    do_cmpl(3'd0, 32'h0, 1'b0);
    repeat (3) @(negedge clk);
    for (int j = 0; j < 8; j++)
      do_alloc(5'(20 + j), 32'h3000 + 32'(4 * j), 3'(3 + j));
    chk(alloc_ready == 1'b0, "R4 R3 refull", {31'd0, alloc_ready}, 32'd0);

    // R5 exception behind unfinished head waits
    do_cmpl(3'd4, 32'hB004, 1'b1);
    repeat (4) @(negedge clk);
    chk(n_done == 1 && n_rest == 3, "R5 waits", n_done, 32'd1);
    do_cmpl(3'd5, 32'hB005, 1'b0);
    do_cmpl(3'd3, 32'hB003, 1'b0);
    wait_done(1);
    chk(n_done == 2, "R5 R7 done", n_done, 32'd2);
    chk(n_rest == 4, "R6 skip", n_rest, 32'd4);
    chk(log_idx[3] == 5'd22 && log_val[3] == 32'hB005, "R6 wrap entry", log_val[3], 32'hB005);
    chk(last_pc == 32'h3004, "R7 pc2", last_pc, 32'h3004);
    @(negedge clk);
    chk(alloc_ready == 1'b1 && alloc_slot == 3'd0, "R7 empty2", {29'd0, alloc_slot}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule